// File: doc/BRIEF.md
# Attribute-Capable Pixel Serializer

This block turns screen bytes, delivered over a valid/ready stream, into one 3-bit RGB value per pixel clock. Each stream byte carries a tag that marks it as bitmap data or as an attribute byte. Bitmap bytes are shifted out one bit per pixel, and each pixel is held for one, two or four clocks. In the monochrome setting, set bits are white and clear bits are black. In the two attribute settings, a set bit and a clear bit each take a colour chosen by that column's attribute, through a fixed 16-entry colour map.

Attributes are only streamed on the first pixel row of a character (row 0). They are kept in a 40-entry line store indexed by character column, and rows 1 to 7 reuse them. A line opens with a one-clock `line_start` pulse, then 8 black lead-in clocks and then 640 pixel clocks. The lead-in lets the first column's attribute and bitmap arrive before the first pixel. The block pulls bytes as it needs them. If a column's bitmap has not arrived when that column begins, the column is shown black.

Back-pressure rules: a byte moves on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` depends only on internal state, never on the inputs in the same cycle. The source must hold its byte and tag stable until that byte is accepted. `scale_sel`, `attr_mode` and `char_row` are expected to stay constant from `line_start` until the line ends.

Top module: `pxser_top`

## Requirements
- R1: `in_ready` is high only after a `line_start` pulse, only while the one-byte bitmap hold is empty, and only until the bitmap for the line's last column has been taken into the shifter. Every accepted byte is consumed, whatever its tag. After reset `in_ready` is low.
- R2: Suppose `line_start` is sampled high at a rising edge. For the next 8 clocks the output is 000. Pixel i (0 to 639) appears in clock 9+i after that edge. From then until the next `line_start` the output is 000, and it is also 000 after reset.
- R3: Each bitmap byte gives 8 pixels, bit 7 first and bit 0 last.
- R4: With `scale_sel` 00, 01 or 10, each pixel lasts 1, 2 or 4 clocks, and the line holds 80, 40 or 20 columns. Code 11 behaves as 10.
- R5: With `attr_mode` 00, a set bit gives RGB 111 and a clear bit gives 000. Attribute-tagged bytes are accepted and have no effect.
- R6: With `attr_mode` 10 or 11, column c uses attribute entry c. A set bit shows cmap(bits 3:0) and a clear bit shows cmap(bits 7:4). Here cmap(i) is i for i below 8 and 15-i otherwise.
- R7: With `attr_mode` 01, entry k covers columns 2k (bits 3:0) and 2k+1 (bits 7:4). Within that nibble, a set bit shows cmap(nibble bits 1:0) and a clear bit shows cmap(nibble bits 3:2).
- R8: Attribute bytes are stored only when `char_row` is 0 and `attr_mode` is not 00. The n-th stored byte of a line goes to entry n, counting from 0 at `line_start`. Bytes beyond entry 39 are dropped, and columns that map to an entry of 40 or more read attribute 0. On rows 1 to 7, attribute-tagged bytes are dropped and the stored entries are reused.
- R9: If the bitmap hold is empty when a column starts, that whole column is shown as 000.
- R10: While `disp_en` is low, the output is 000 in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-clock pulse that opens a line |
| scale_sel | input | 2 | Horizontal scale: 00 x1, 01 x2, 10/11 x4 |
| attr_mode | input | 2 | 00 monochrome, 01 half-rate nibbles, 10/11 full byte |
| char_row | input | 3 | Pixel row inside the character, 0 to 7 |
| disp_en | input | 1 | Display enable; low forces black |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Block can take a byte this clock |
| in_data | input | 8 | Stream byte |
| in_is_attr | input | 1 | 1 = attribute byte, 0 = bitmap byte |
| rgb_o | output | 3 | Pixel colour |

## Verification
Monochrome lines are run at every scale code, and every clock is compared. This separates bit order, the pixel hold length and the column count, and shows that code 11 matches x4. Full-byte and nibble lines on row 0 are each followed by a later row that carries stray attribute bytes. A change in the later row would show that the store was overwritten, and the full-byte line at x1 exercises the entries beyond the store depth. A source that stalls across one column boundary shows the black underrun column and the correct realignment after it, and a low `disp_en` window during an attribute line shows the masking.

// File: rtl/pxser_pkg.sv
package pxser_pkg;

  localparam int LEAD_CYC = 8;
  localparam int CHAR_PIX = 8;

  typedef enum logic [1:0] {
    AM_MONO = 2'b00,
    AM_HALF = 2'b01,
    AM_FULL = 2'b10,
    AM_FULL_ALT = 2'b11
  } amode_t;

  // fixed 16-entry colour map: low half direct, high half mirrored
  function automatic logic [2:0] cmap(input logic [3:0] idx);
    return idx[3] ? ~idx[2:0] : idx[2:0];
  endfunction

  // log2 of the pixel hold length; code 3 folds onto x4
  function automatic logic [1:0] scale_log2(input logic [1:0] code);
    return (code == 2'b11) ? 2'b10 : code;
  endfunction

endpackage

// File: rtl/pxser_line_timer.sv
module pxser_line_timer
  import pxser_pkg::*;
#(
  parameter int LINE_PIX = 640,
  parameter int COL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [1:0]       scale_sel,
  output logic             pix_on,
  output logic             shift_en,
  output logic             ld,
  output logic             ld_last,
  output logic [COL_W-1:0] rd_col
);
  localparam int MAX_COLS = LINE_PIX / CHAR_PIX;
  localparam int CYC_W = $clog2(LEAD_CYC + LINE_PIX);

  logic             run;
  logic [CYC_W-1:0] cyc;
  logic [1:0]       hold_cnt;
  logic [2:0]       bit_cnt;
  logic [COL_W-1:0] col;

  logic [1:0]       lsh;
  logic [1:0]       hold_lim;
  logic [COL_W-1:0] last_col;
  logic             lead_end;
  logic             end_hold;
  logic             char_end;

  always_comb begin
    lsh      = scale_log2(scale_sel);
    hold_lim = 2'((3'd1 << lsh) - 3'd1);
    last_col = COL_W'(MAX_COLS >> lsh) - COL_W'(1);
    pix_on   = run && (cyc >= CYC_W'(LEAD_CYC));
    lead_end = run && (cyc == CYC_W'(LEAD_CYC - 1));
    end_hold = pix_on && (hold_cnt == hold_lim);
    char_end = end_hold && (bit_cnt == 3'd7);
    ld       = lead_end || (char_end && (col != last_col));
    rd_col   = lead_end ? '0 : col + COL_W'(1);
    ld_last  = ld && (rd_col == last_col);
    shift_en = end_hold;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      cyc      <= '0;
      hold_cnt <= '0;
      bit_cnt  <= '0;
      col      <= '0;
    end else if (line_start) begin
      run      <= 1'b1;
      cyc      <= '0;
      hold_cnt <= '0;
      bit_cnt  <= '0;
      col      <= '0;
    end else if (run) begin
      if (cyc == CYC_W'(LEAD_CYC + LINE_PIX - 1)) run <= 1'b0;
      cyc <= cyc + CYC_W'(1);
      if (pix_on) begin
        if (end_hold) begin
          hold_cnt <= '0;
          bit_cnt  <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7 && col != last_col) col <= col + COL_W'(1);
        end else begin
          hold_cnt <= hold_cnt + 2'd1;
        end
      end
    end
  end

  AST_LD_SPACING: assert property (@(posedge clk) disable iff (!rst_n) ld |=> !ld); // R4
  AST_LEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) line_start |=> !pix_on); // R2

endmodule

// File: rtl/pxser_attr_store.sv
module pxser_attr_store #(
  parameter int DEPTH = 40,
  parameter int COL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             attr_fire,
  input  logic             attr_on,
  input  logic             half_mode,
  input  logic [2:0]       char_row,
  input  logic [7:0]       wr_data,
  input  logic [COL_W-1:0] rd_col,
  output logic [7:0]       rd_attr
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(DEPTH + 1);

  logic [7:0]       mem [DEPTH];
  logic [PW-1:0]    wptr;
  logic             we;
  logic [COL_W-1:0] idx;
  logic [7:0]       entry;
  logic [3:0]       nib;

  assign we = attr_fire && attr_on && (char_row == 3'd0) && (wptr < PW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else begin
      if (line_start) wptr <= '0;
      else if (we) wptr <= wptr + PW'(1);
      if (we) mem[AW'(wptr)] <= wr_data;
    end
  end

  always_comb begin
    idx     = half_mode ? (rd_col >> 1) : rd_col;
    entry   = (idx < COL_W'(DEPTH)) ? mem[AW'(idx)] : 8'h00;
    nib     = rd_col[0] ? entry[7:4] : entry[3:0];
    rd_attr = half_mode ? {4'h0, nib} : entry;
  end

  AST_ROW_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (char_row != 3'd0 && !line_start) |=> $stable(wptr)); // R8

endmodule

// File: rtl/pxser_shift_unit.sv
module pxser_shift_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic       shift_en,
  input  logic       hold_full,
  input  logic [7:0] hold_byte,
  input  logic [7:0] rd_attr,
  output logic       px_bit,
  output logic       char_ok,
  output logic [7:0] cur_attr
);
  logic [7:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '0;
      char_ok  <= 1'b0;
      cur_attr <= '0;
    end else if (ld) begin
      sh       <= hold_full ? hold_byte : 8'h00;
      char_ok  <= hold_full;
      cur_attr <= rd_attr;
    end else if (shift_en) begin
      sh <= {sh[6:0], 1'b0};
    end
  end

  assign px_bit = sh[7];

  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && hold_full) |=> (px_bit == $past(hold_byte[7]))); // R3

endmodule

// File: rtl/pxser_top.sv
module pxser_top
  import pxser_pkg::*;
#(
  parameter int LINE_PIX = 640,
  parameter int ATTR_DEPTH = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start,
  input  logic [1:0] scale_sel,
  input  logic [1:0] attr_mode,
  input  logic [2:0] char_row,
  input  logic       disp_en,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_is_attr,
  output logic [2:0] rgb_o
);
  localparam int MAX_COLS = LINE_PIX / CHAR_PIX;
  localparam int COL_W = $clog2(MAX_COLS);

  logic             fetch_on;
  logic             hold_full;
  logic [7:0]       hold_byte;
  logic             fire, bm_fire, attr_fire;
  logic             pix_on, shift_en, ld, ld_last;
  logic [COL_W-1:0] rd_col;
  logic [7:0]       rd_attr, cur_attr;
  logic             px_bit, char_ok;
  logic [2:0]       pick;
  amode_t           mode;

  assign mode      = amode_t'(attr_mode);
  assign in_ready  = fetch_on && !hold_full;
  assign fire      = in_valid && in_ready;
  assign bm_fire   = fire && !in_is_attr;
  assign attr_fire = fire && in_is_attr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_on  <= 1'b0;
      hold_full <= 1'b0;
      hold_byte <= '0;
    end else begin
      if (line_start) fetch_on <= 1'b1;
      else if (ld_last) fetch_on <= 1'b0;
      if (bm_fire) begin
        hold_full <= 1'b1;
        hold_byte <= in_data;
      end else if (ld) begin
        hold_full <= 1'b0;
      end
    end
  end

  pxser_line_timer #(.LINE_PIX(LINE_PIX), .COL_W(COL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .scale_sel(scale_sel),
    .pix_on(pix_on), .shift_en(shift_en), .ld(ld), .ld_last(ld_last), .rd_col(rd_col)
  );

  pxser_attr_store #(.DEPTH(ATTR_DEPTH), .COL_W(COL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .attr_fire(attr_fire),
    .attr_on(mode != AM_MONO), .half_mode(mode == AM_HALF), .char_row(char_row),
    .wr_data(in_data), .rd_col(rd_col), .rd_attr(rd_attr)
  );

  pxser_shift_unit u_shift (
    .clk(clk), .rst_n(rst_n), .ld(ld), .shift_en(shift_en), .hold_full(hold_full),
    .hold_byte(hold_byte), .rd_attr(rd_attr), .px_bit(px_bit), .char_ok(char_ok),
    .cur_attr(cur_attr)
  );

  always_comb begin
    case (mode)
      AM_MONO: pick = px_bit ? 3'b111 : 3'b000;
      AM_HALF: pick = px_bit ? cmap({2'b00, cur_attr[1:0]}) : cmap({2'b00, cur_attr[3:2]});
      default: pick = px_bit ? cmap(cur_attr[3:0]) : cmap(cur_attr[7:4]);
    endcase
    rgb_o = (disp_en && pix_on && char_ok) ? pick : 3'b000;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) bm_fire |=> !in_ready); // R1
  AST_FETCH_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) ld_last |=> !in_ready); // R1
  AST_LEAD_BLACK: assert property (@(posedge clk) disable iff (!rst_n) line_start |=> (rgb_o == 3'b000)); // R2
  AST_UNDERRUN_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !hold_full) |=> (rgb_o == 3'b000)); // R9

endmodule

// File: tb/tb_pxser_top.sv
module tb_pxser_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_start;
  logic [1:0] scale_sel;
  logic [1:0] attr_mode;
  logic [2:0] char_row;
  logic       disp_en;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       in_is_attr;
  logic [2:0] rgb_o;

  always #10 clk = ~clk;

  pxser_top dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .scale_sel(scale_sel),
    .attr_mode(attr_mode), .char_row(char_row), .disp_en(disp_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_is_attr(in_is_attr), .rgb_o(rgb_o)
  );

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] bm [80];
  logic [7:0] ref_buf [40];
  logic [7:0] s_dat [256];
  logic       s_att [256];
  int         s_len;

  function automatic logic [2:0] ref_map(int i);
    return (i < 8) ? 3'(i) : 3'(7 - (i - 8));
  endfunction

  task automatic check(input string rq, input int got, input int exp, input int rel);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s rel=%0d actual=%0d expected=%0d", rq, rel, got, exp);
    end
  endtask

  task automatic run_line(input int sc_code, input int md, input int row, input bit junk,
                          input int uc, input int dlo, input int dhi, input int seed,
                          input string tag);
    int pw;
    int stall_pos;
    int stall_end;
    int idx;
    bit fire;
    int nw;
    pw = (sc_code == 3) ? 4 : (1 << sc_code);
    stall_pos = -1;
    stall_end = 8 + uc * 8 * pw;
    idx = 0;
    fire = 1'b0;
    nw = 0;
    s_len = 0;
    for (int c = 0; c < 80 / pw; c++) begin
      bm[c] = 8'(c * 53 + seed * 97 + 3);
      if (c == uc + 1) stall_pos = s_len;
      if (c == uc) continue;
      if (md != 0 && row == 0 && (md != 1 || c % 2 == 0)) begin
        s_dat[s_len] = 8'(c * 73 + seed * 29 + 11);
        s_att[s_len] = 1'b1;
        if (nw < 40) ref_buf[nw] = s_dat[s_len];
        nw++;
        s_len++;
      end
      if (junk && c % 2 == 0 && !(md != 0 && row == 0)) begin
        s_dat[s_len] = 8'hA5;
        s_att[s_len] = 1'b1;
        s_len++;
      end
      s_dat[s_len] = bm[c];
      s_att[s_len] = 1'b0;
      s_len++;
    end
    scale_sel = 2'(sc_code);
    attr_mode = 2'(md);
    char_row  = 3'(row);
    for (int rel = 0; rel <= 660; rel++) begin
      @(negedge clk);
      if (fire) idx++;
      line_start = (rel == 0);
      in_valid   = (idx < s_len) && !(idx == stall_pos && rel <= stall_end);
      in_data    = (idx < s_len) ? s_dat[idx] : 8'h00;
      in_is_attr = (idx < s_len) ? s_att[idx] : 1'b0;
      disp_en    = !(rel >= dlo && rel < dhi);
      #1;
      if (rel >= 1) begin
        int cy;
        int exp;
        string rq;
        cy = rel - 1;
        exp = 0;
        rq = "R2";
        if (cy >= 8 && cy < 648) begin
          int i, c, b, ai;
          logic bitv;
          logic [7:0] a;
          logic [3:0] nib;
          i = cy - 8;
          c = i / (8 * pw);
          b = (i / pw) % 8;
          bitv = bm[c][7 - b];
          rq = tag;
          if (c == uc) begin
            rq = "R9";
            exp = 0;
          end else if (md == 0) begin
            exp = bitv ? 7 : 0;
          end else if (md == 1) begin
            ai = c >> 1;
            a = (ai < 40) ? ref_buf[ai] : 8'h00;
            nib = (c % 2 == 1) ? a[7:4] : a[3:0];
            exp = bitv ? int'(ref_map(int'(nib[1:0]))) : int'(ref_map(int'(nib[3:2])));
          end else begin
            a = (c < 40) ? ref_buf[c] : 8'h00;
            exp = bitv ? int'(ref_map(int'(a[3:0]))) : int'(ref_map(int'(a[7:4])));
          end
        end
        if (!disp_en) begin
          exp = 0;
          rq = "R10";
        end
        check(rq, int'(rgb_o), exp, rel);
      end
      if (rel == 1) check("R1 ready after line_start", int'(in_ready), 1, rel);
      fire = in_valid && in_ready;
    end
    @(negedge clk);
    if (fire) idx++;
    in_valid = 1'b0;
    disp_en = 1'b1;
    #1;
    check("R1 bytes consumed", idx, s_len, 661);
    check("R1 ready closed", int'(in_ready), 0, 661);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 40; k++) ref_buf[k] = 8'h00;
    rst_n = 1'b0;
    line_start = 1'b0;
    scale_sel = 2'b00;
    attr_mode = 2'b00;
    char_row = 3'd0;
    disp_en = 1'b1;
    in_valid = 1'b0;
    in_data = 8'h00;
    in_is_attr = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check("R1 reset ready", int'(in_ready), 0, 0);
    check("R2 reset black", int'(rgb_o), 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // monochrome at each scale code: R3 bit order, R4 hold length, R5 colours and dropped attributes
    run_line(0, 0, 0, 1'b0, -1, -1, -1, 1, "R3/R5");
    run_line(1, 0, 0, 1'b1, -1, -1, -1, 2, "R4/R5");
    run_line(2, 0, 2, 1'b0, -1, -1, -1, 3, "R4");
    run_line(3, 0, 0, 1'b0, -1, -1, -1, 4, "R4");
    // full-byte attributes, then a later row with stray attribute bytes
    run_line(1, 2, 0, 1'b0, -1, -1, -1, 5, "R6");
    run_line(1, 2, 3, 1'b1, -1, -1, -1, 6, "R8");
    // half-rate nibbles, then reuse on a later row
    run_line(0, 1, 0, 1'b0, -1, -1, -1, 7, "R7");
    run_line(0, 1, 5, 1'b1, -1, -1, -1, 8, "R8");
    run_line(2, 1, 0, 1'b0, -1, -1, -1, 9, "R7");
    // full-byte at x1: columns 40..79 beyond store depth read attribute 0
    run_line(0, 2, 0, 1'b0, -1, -1, -1, 10, "R8");
    // mode code 11 as full byte, with a display-enable gap
    run_line(2, 3, 0, 1'b0, -1, 100, 250, 11, "R6");
    // source stall across the start of column 5
    run_line(1, 0, 0, 1'b0, 5, -1, -1, 12, "R9/R5");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule